// File: doc/BRIEF.md
# Auto-Increment Prefetch and Ready Controller

This block is the memory-side sequencer that sits behind a host port's register decoder. The decoder hands it whole-word commands: load the address pointer, write a word, read a word. Each data command can ask for the pointer to step to the next word afterwards. The sequencer runs every data access on a simple request/acknowledge memory port, always at the current pointer. It keeps at most one transaction outstanding at a time.

When a read asks for auto-increment, the sequencer steps the pointer. It then fetches the word at the new pointer into a one-word buffer straight away. The next incrementing read is then answered from that buffer without waiting on memory. A ready output is high only when no memory transaction is outstanding, which holds the host off while a write or a prefetch is still in flight. The same state is also given as a status bit, so that a control register can show it to hosts that poll instead of using the pin.

Top module: `hpi_autoinc_seq`

## Requirements
- R1: After reset, the pointer is 0, ready is 1, no memory request is raised, no read data is flagged valid and the prefetch buffer is empty.
- R2: A pointer load accepted while ready sets the pointer to the given value in the next cycle and discards any prefetched word, so the next read fetches from the new address.
- R3: An accepted data write raises one memory request with write-enable 1, the pointer as address, and the command's data and byte enables (one enable bit per byte, bit i for bits 8i+7..8i). It completes on acknowledge.
- R4: When a data command carries increment set, the pointer advances by exactly one word as that word completes. Without it, the pointer stays unchanged.
- R5: A read without increment always fetches fresh from the pointer and never prefetches. The read-valid strobe is high for exactly one cycle, the cycle after the acknowledge, carrying the memory data.
- R6: A read with increment and an empty buffer fetches at the pointer and returns the data the cycle after the acknowledge. The pointer then advances, and the request stays raised in that same cycle, now at the new address, as a prefetch.
- R7: A read with increment that finds the buffer full returns the buffered word in the next cycle without waiting for memory. It advances the pointer and starts the prefetch of the following word.
- R8: Ready is high exactly when no memory transaction is outstanding, so it stays low through a write, a demand read and a prefetch until the acknowledge.
- R9: Commands presented while ready is low are ignored. They do not change the pointer, the buffer or the memory traffic.
- R10: The status bit equals the ready output in every cycle.
- R11: Only one memory transaction is outstanding. While the request waits for acknowledge, its address, direction, data and byte enables stay stable.
- R12: If several commands arrive in the same ready cycle, a pointer load wins over a data write, and a data write wins over a data read. The losers are dropped.
- R13: A data write, or a read without increment, discards a prefetched word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ptr_wr | input | 1 | Load pointer command |
| ptr_wdata | input | AW | New pointer value (word address) |
| dat_wr | input | 1 | Data write command |
| dat_rd | input | 1 | Data read command |
| dat_inc | input | 1 | Step pointer after this data command |
| dat_wdata | input | DW | Write data |
| dat_be | input | DW/8 | Byte enables for write |
| rd_valid | output | 1 | One-cycle strobe: rd_data holds the read word |
| rd_data | output | DW | Read word |
| ptr_value | output | AW | Current pointer |
| host_rdy | output | 1 | High when a command will be accepted |
| ctl_rdy_bit | output | 1 | Ready state for a control register |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_be | output | DW/8 | Memory byte enables |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | DW | Memory read data, valid with mem_ack |

## Verification
The bench goes after a pointer load that lands while a prefetched word is held. A design that kept the buffer would return the old word for the new address. It also drives a prefetch acknowledged with zero latency straight after a demand read, where a design that dropped the request for a cycle, or stepped the pointer twice, would fetch the wrong word. Commands pushed in while ready is low, and commands arriving together, are checked at the pointer and the memory port: a design that accepted them would start extra traffic. A read without increment after a prefetch is checked to go to memory, since a design that wrongly used the buffer would answer a cycle early with data that may be stale.

// File: rtl/hpi_seq_pkg.sv
// Shared types for the auto-increment sequencer.
// Assumes: one command decoded per cycle, whole-word transfers only.
package hpi_seq_pkg;

    // Sequencer phase: what the memory port is doing right now.
    typedef enum logic [1:0] {
        SQ_IDLE     = 2'd0,
        SQ_DEMAND   = 2'd1,
        SQ_STORE    = 2'd2,
        SQ_PREFETCH = 2'd3
    } seq_state_e;

    // Host command after priority selection.
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_PTR   = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } host_op_e;

endpackage

// File: rtl/hpi_cmd_select.sv
// Picks at most one host command per cycle.
// Pointer load beats data write, data write beats data read.
// Assumes: commands are only meaningful while accept is high; otherwise dropped.
module hpi_cmd_select
    import hpi_seq_pkg::*;
(
    input  logic     accept,
    input  logic     ptr_wr,
    input  logic     dat_wr,
    input  logic     dat_rd,
    output host_op_e op
);

    // Fixed-priority choice, gated by acceptance.
    always_comb begin
        op = OP_NONE;
        if (accept) begin
            if (ptr_wr)      op = OP_PTR;
            else if (dat_wr) op = OP_WRITE;
            else if (dat_rd) op = OP_READ;
        end
    end

endmodule

// File: rtl/hpi_ptr_unit.sv
// Word-address pointer: loaded by the host, stepped by one per completed word.
// Assumes: load and step are never requested in the same cycle.
module hpi_ptr_unit #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] ptr
);

    localparam logic [AW-1:0] ONE = AW'(1);

    // Pointer register update.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (load) ptr <= load_val;
        else if (step) ptr <= ptr + ONE;
    end

    // R2: a load takes priority over stepping and lands in the next cycle.
    assert_load_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ptr == $past(load_val)));

endmodule

// File: rtl/hpi_prefetch_buf.sv
// One-word prefetch holder. Filled by a completed prefetch, emptied when the
// host consumes it or when anything makes it stale.
// Assumes: fill never coincides with take or drop.
module hpi_prefetch_buf #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fill,
    input  logic [DW-1:0] fill_data,
    input  logic          take,
    input  logic          drop,
    output logic          valid,
    output logic [DW-1:0] data
);

    // Valid flag: cleared by consume or invalidate, set by fill.
    always_ff @(posedge clk) begin
        if (!rst_n)            valid <= 1'b0;
        else if (take || drop) valid <= 1'b0;
        else if (fill)         valid <= 1'b1;
    end

    // Data holder: captures the prefetched word.
    always_ff @(posedge clk) begin
        if (!rst_n)    data <= '0;
        else if (fill) data <= fill_data;
    end

    // R13: a drop always leaves the buffer empty in the next cycle.
    assert_drop_empties_R13: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> !valid);

endmodule

// File: rtl/hpi_mem_seq.sv
// Memory-side sequencer: runs demand reads, writes and prefetches one at a
// time on a request/acknowledge port, and drives host ready.
// Assumes: mem_ack is a single-cycle pulse answering the raised request.
module hpi_mem_seq
    import hpi_seq_pkg::*;
#(
    parameter int DW  = 32,
    parameter int BEW = DW / 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  host_op_e       op,
    input  logic           inc,
    input  logic [DW-1:0]  wdata,
    input  logic [BEW-1:0] be,
    input  logic           buf_valid,
    input  logic [DW-1:0]  buf_data,
    input  logic           mem_ack,
    input  logic [DW-1:0]  mem_rdata,
    output logic           mem_req,
    output logic           mem_we,
    output logic [DW-1:0]  mem_wdata,
    output logic [BEW-1:0] mem_be,
    output logic           ptr_load,
    output logic           ptr_step,
    output logic           buf_fill,
    output logic           buf_take,
    output logic           buf_drop,
    output logic           rd_valid,
    output logic [DW-1:0]  rd_data,
    output logic           host_rdy
);

    seq_state_e state, state_nx;
    logic       inc_q;
    logic       hit;
    logic       rd_fire;

    assign hit       = (op == OP_READ) && inc && buf_valid;
    assign mem_req   = (state != SQ_IDLE);
    assign mem_we    = (state == SQ_STORE);
    assign host_rdy  = (state == SQ_IDLE);

    // Next-phase and side-effect decode.
    always_comb begin
        state_nx = state;
        ptr_load = 1'b0;
        ptr_step = 1'b0;
        buf_fill = 1'b0;
        buf_take = 1'b0;
        buf_drop = 1'b0;
        rd_fire  = 1'b0;
        unique case (state)
            SQ_IDLE: begin
                unique case (op)
                    OP_PTR: begin
                        ptr_load = 1'b1;
                        buf_drop = 1'b1;
                    end
                    OP_WRITE: begin
                        state_nx = SQ_STORE;
                        buf_drop = 1'b1;
                    end
                    OP_READ: begin
                        if (hit) begin
                            buf_take = 1'b1;
                            ptr_step = 1'b1;
                            rd_fire  = 1'b1;
                            state_nx = SQ_PREFETCH;
                        end else begin
                            buf_drop = 1'b1;
                            state_nx = SQ_DEMAND;
                        end
                    end
                    default: ;
                endcase
            end
            SQ_DEMAND: begin
                if (mem_ack) begin
                    rd_fire  = 1'b1;
                    ptr_step = inc_q;
                    state_nx = inc_q ? SQ_PREFETCH : SQ_IDLE;
                end
            end
            SQ_STORE: begin
                if (mem_ack) begin
                    ptr_step = inc_q;
                    state_nx = SQ_IDLE;
                end
            end
            SQ_PREFETCH: begin
                if (mem_ack) begin
                    buf_fill = 1'b1;
                    state_nx = SQ_IDLE;
                end
            end
            default: state_nx = SQ_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= state_nx;
    end

    // Latch the command's increment flag, data and enables on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_q     <= 1'b0;
            mem_wdata <= '0;
            mem_be    <= '0;
        end else if (state == SQ_IDLE && op != OP_NONE && op != OP_PTR) begin
            inc_q <= inc;
            if (op == OP_WRITE) begin
                mem_wdata <= wdata;
                mem_be    <= be;
            end
        end
    end

    // Host read return: buffered word on a hit, memory word on a demand ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_fire;
            if (rd_fire) rd_data <= (state == SQ_IDLE) ? buf_data : mem_rdata;
        end
    end

    // R11: a waiting request keeps its direction, data and enables.
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && mem_we == $past(mem_we)
                                   && $stable(mem_wdata) && $stable(mem_be)));

    // R5: the read strobe never lasts more than one cycle.
    assert_rd_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R8: host is held off in the cycle after any accepted data command.
    assert_busy_after_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdy && (op == OP_WRITE || op == OP_READ)) |=> !host_rdy);

endmodule

// File: rtl/hpi_autoinc_seq.sv
// Top: auto-increment prefetch and ready controller behind a host port.
// Combines command selection, the pointer, the prefetch buffer and the
// memory sequencer. Assumes a register decoder upstream that has already
// assembled whole words and presents single-cycle command pulses.
module hpi_autoinc_seq
    import hpi_seq_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 32,
    parameter int BEW = DW / 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ptr_wr,
    input  logic [AW-1:0]  ptr_wdata,
    input  logic           dat_wr,
    input  logic           dat_rd,
    input  logic           dat_inc,
    input  logic [DW-1:0]  dat_wdata,
    input  logic [BEW-1:0] dat_be,
    output logic           rd_valid,
    output logic [DW-1:0]  rd_data,
    output logic [AW-1:0]  ptr_value,
    output logic           host_rdy,
    output logic           ctl_rdy_bit,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    output logic [BEW-1:0] mem_be,
    input  logic           mem_ack,
    input  logic [DW-1:0]  mem_rdata
);

    host_op_e      op;
    logic          ptr_load, ptr_step;
    logic          buf_fill, buf_take, buf_drop, buf_valid;
    logic [DW-1:0] buf_data;

    hpi_cmd_select u_sel (
        .accept (host_rdy),
        .ptr_wr (ptr_wr),
        .dat_wr (dat_wr),
        .dat_rd (dat_rd),
        .op     (op)
    );

    hpi_ptr_unit #(.AW(AW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (ptr_wdata),
        .step     (ptr_step),
        .ptr      (ptr_value)
    );

    hpi_prefetch_buf #(.DW(DW)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill      (buf_fill),
        .fill_data (mem_rdata),
        .take      (buf_take),
        .drop      (buf_drop),
        .valid     (buf_valid),
        .data      (buf_data)
    );

    hpi_mem_seq #(.DW(DW), .BEW(BEW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .inc       (dat_inc),
        .wdata     (dat_wdata),
        .be        (dat_be),
        .buf_valid (buf_valid),
        .buf_data  (buf_data),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_be    (mem_be),
        .ptr_load  (ptr_load),
        .ptr_step  (ptr_step),
        .buf_fill  (buf_fill),
        .buf_take  (buf_take),
        .buf_drop  (buf_drop),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .host_rdy  (host_rdy)
    );

    // Memory address is the pointer itself; ready state mirrored for polling.
    assign mem_addr    = ptr_value;
    assign ctl_rdy_bit = host_rdy;

    // R11: the address of a waiting request does not move.
    assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> $stable(mem_addr));

    // R4: the pointer only ever steps by one word or takes a host load.
    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr_value) |-> ((ptr_value == $past(ptr_value) + AW'(1)) || $past(ptr_wr)));

    // R7: a prefetched word is only held while the memory port is quiet.
    assert_buf_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_valid |-> !mem_req);

endmodule

// File: tb/hpi_autoinc_seq_test.sv
// Bench: behavioural reference model compared against the design every clock.
module hpi_autoinc_seq_test;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int BW = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ptr_wr = 1'b0, dat_wr = 1'b0, dat_rd = 1'b0, dat_inc = 1'b0;
    logic [AW-1:0] ptr_wdata = '0;
    logic [DW-1:0] dat_wdata = '0;
    logic [BW-1:0] dat_be = '0;
    logic          rd_valid, host_rdy, ctl_rdy_bit, mem_req, mem_we;
    logic [DW-1:0] rd_data, mem_wdata;
    logic [AW-1:0] ptr_value, mem_addr;
    logic [BW-1:0] mem_be;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = 32'hDEAD_BEEF;

    hpi_autoinc_seq #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
        .dat_wr(dat_wr), .dat_rd(dat_rd), .dat_inc(dat_inc),
        .dat_wdata(dat_wdata), .dat_be(dat_be), .rd_valid(rd_valid),
        .rd_data(rd_data), .ptr_value(ptr_value), .host_rdy(host_rdy),
        .ctl_rdy_bit(ctl_rdy_bit), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #2 clk = ~clk;  // 250 MHz

    int checks = 0, fails = 0, cycles = 0;
    logic [DW-1:0] store [256];
    int lat = 1, wait_cnt = 0;

    // Reference model state: 0 idle, 1 demand read, 2 write, 3 prefetch.
    int            m_st = 0;
    logic [AW-1:0] m_ptr = '0;
    bit            m_have = 0, m_inc = 0, m_rv = 0;
    logic [DW-1:0] m_buf = '0, m_rd = '0, m_wd = '0;
    logic [BW-1:0] m_be = '0;
    string         m_tag = "R5";

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Reference model: advance one clock using the inputs seen at this edge.
    always @(posedge clk) begin
        m_rv = 0;
        if (!rst_n) begin
            m_st = 0; m_ptr = '0; m_have = 0;
        end else begin
            case (m_st)
                0: begin
                    if (ptr_wr) begin
                        m_ptr = ptr_wdata; m_have = 0;
                    end else if (dat_wr) begin
                        m_st = 2; m_inc = dat_inc; m_wd = dat_wdata; m_be = dat_be; m_have = 0;
                    end else if (dat_rd) begin
                        if (dat_inc && m_have) begin
                            m_rv = 1; m_rd = m_buf; m_have = 0; m_ptr = m_ptr + 1'b1;
                            m_st = 3; m_tag = "R7";
                        end else begin
                            m_st = 1; m_inc = dat_inc; m_have = 0;
                            m_tag = dat_inc ? "R6" : "R5";
                        end
                    end
                end
                1: if (mem_ack) begin
                    m_rv = 1; m_rd = store[m_ptr[7:0]];
                    if (m_inc) begin m_ptr = m_ptr + 1'b1; m_st = 3; end
                    else m_st = 0;
                end
                2: if (mem_ack) begin
                    if (m_inc) m_ptr = m_ptr + 1'b1;
                    m_st = 0;
                end
                default: if (mem_ack) begin
                    m_buf = store[m_ptr[7:0]]; m_have = 1; m_st = 0;
                end
            endcase
        end
    end

    // Per-cycle comparison, then the memory responder, both away from the rising edge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check(host_rdy == (m_st == 0), "R8 ready", host_rdy, m_st == 0);
            check(ctl_rdy_bit == host_rdy, "R10 status", ctl_rdy_bit, host_rdy);
            check(ptr_value == m_ptr, "R2/R4 pointer", ptr_value, m_ptr);
            check(rd_valid == m_rv, {m_tag, " read strobe"}, rd_valid, m_rv);
            if (m_rv) check(rd_data == m_rd, {m_tag, " read data"}, rd_data, m_rd);
            check(mem_req == (m_st != 0), "R11 request", mem_req, m_st != 0);
            if (mem_req) begin
                check(mem_addr == m_ptr, "R11 address", mem_addr, m_ptr);
                check(mem_we == (m_st == 2), "R3 direction", mem_we, m_st == 2);
                if (m_st == 2) begin
                    check(mem_wdata == m_wd, "R3 write data", mem_wdata, m_wd);
                    check(mem_be == m_be, "R3 byte enables", mem_be, m_be);
                end
            end
        end
        if (mem_ack) begin
            mem_ack = 1'b0; mem_rdata = 32'hDEAD_BEEF; wait_cnt = 0;
        end else if (mem_req) begin
            if (wait_cnt >= lat) begin
                if (mem_we) begin
                    for (int b = 0; b < BW; b++)
                        if (mem_be[b]) store[mem_addr[7:0]][8*b +: 8] = mem_wdata[8*b +: 8];
                end else mem_rdata = store[mem_addr[7:0]];
                mem_ack = 1'b1;
            end else wait_cnt++;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) if (cycles > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Present one command at a negedge for one cycle; mask bit0 ptr, bit1 write, bit2 read.
    task automatic issue(input int mask, input logic [AW-1:0] p, input logic [DW-1:0] d,
                         input logic [BW-1:0] be, input bit inc, input bit wait_ready);
        if (wait_ready) while (!host_rdy) @(negedge clk);
        ptr_wr = mask[0]; dat_wr = mask[1]; dat_rd = mask[2];
        ptr_wdata = p; dat_wdata = d; dat_be = be; dat_inc = inc;
        @(negedge clk);
        ptr_wr = 0; dat_wr = 0; dat_rd = 0; dat_inc = 0;
    endtask

    task automatic settle();
        while (!host_rdy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) store[i] = 32'hC0DE_0000 + i * 32'h0001_0103;
        repeat (3) @(negedge clk);
        // R1: reset state (still in reset, outputs already cleared)
        check(host_rdy == 1'b1, "R1 ready", host_rdy, 1);
        check(ptr_value == '0, "R1 pointer", ptr_value, 0);
        check(mem_req == 1'b0, "R1 request", mem_req, 0);
        check(rd_valid == 1'b0, "R1 strobe", rd_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: plain reads at a loaded pointer, latency 2
        lat = 2;
        issue(1, 16'd10, '0, '0, 0, 1);
        issue(4, '0, '0, '0, 0, 1); settle();
        issue(4, '0, '0, '0, 0, 1); settle();

        // R6 then R7: incrementing read burst
        for (int i = 0; i < 5; i++) begin issue(4, '0, '0, '0, 1, 1); settle(); end

        // R2: pointer load while a word is prefetched, then incrementing read
        issue(1, 16'd40, '0, '0, 0, 1);
        issue(4, '0, '0, '0, 1, 1);
        check(mem_req == 1'b1 && rd_valid == 1'b0, "R2 fetch from new address", {mem_req, rd_valid}, 2'b10);
        settle();

        // R3/R4: incrementing writes with varied enables, latency 3
        lat = 3;
        issue(1, 16'd60, '0, '0, 0, 1);
        issue(2, '0, 32'h1122_3344, 4'hF, 1, 1);
        issue(2, '0, 32'hAABB_CCDD, 4'h5, 1, 1);
        issue(2, '0, 32'h5566_7788, 4'h8, 0, 1);
        settle();
        check(ptr_value == 16'd62, "R4 pointer after writes", ptr_value, 62);

        // read back written words with zero latency prefetching
        lat = 0;
        issue(1, 16'd60, '0, '0, 0, 1);
        for (int i = 0; i < 4; i++) begin issue(4, '0, '0, '0, 1, 1); settle(); end

        // R9: commands while busy are ignored
        lat = 4;
        issue(4, '0, '0, '0, 1, 1);
        issue(1, 16'd200, '0, '0, 0, 0);
        issue(2, '0, 32'hFFFF_FFFF, 4'hF, 1, 0);
        settle();
        check(ptr_value != 16'd200, "R9 pointer untouched", ptr_value, 65);
        check(store[200] != 32'hFFFF_FFFF, "R9 no stray write", store[200], 0);

        // R12: pointer load together with read and write
        lat = 1;
        issue(7, 16'd90, 32'h0BAD_0BAD, 4'hF, 1, 1);
        check(mem_req == 1'b0 && ptr_value == 16'd90, "R12 load wins", {mem_req, ptr_value}, {1'b0, 16'd90});
        issue(6, '0, 32'h0000_1234, 4'h3, 0, 1);
        check(mem_we == 1'b1, "R12 write beats read", mem_we, 1);
        settle();

        // R13: plain read after a prefetch discards the buffered word
        issue(4, '0, '0, '0, 1, 1); settle();
        issue(4, '0, '0, '0, 0, 1); settle();
        issue(4, '0, '0, '0, 1, 1);
        check(mem_req == 1'b1 && rd_valid == 1'b0, "R13 refetch after plain read", {mem_req, rd_valid}, 2'b10);
        settle();
        // R13: write after a prefetch also discards it
        issue(2, '0, 32'h7777_0000, 4'hC, 0, 1); settle();
        issue(4, '0, '0, '0, 1, 1);
        check(mem_req == 1'b1 && rd_valid == 1'b0, "R13 refetch after write", {mem_req, rd_valid}, 2'b10);
        settle();

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule